// File: doc/BRIEF.md
# DRAM refresh request arbiter

This block decides the cycle in which a DRAM refresh may begin. A request can come from three places. An internal periodic timer raises one. An external active-low strobe sets a request latch, which also gives burst refresh. A request/acknowledge handshake lets outside logic see that a refresh is due and service it later. All three sources feed one request latch. That latch is granted only when no access is in progress and the RAS precharge time has been met.

When the request is granted, the block raises a one-cycle `refresh_start` pulse for the refresh cycle sequencer. The sequencer drives the RAS lines and reports with `refresh_end` when the last refresh RAS negates. The single status output has two meanings, selected by `ack_mode`:

- With `ack_mode` low, it is a refresh-in-progress flag. It rises one clock before the sequencer's first refresh RAS.
- With `ack_mode` high, it is a refresh-due flag. It is raised by each timer expiry. It drops for one cycle and rises again for every period that expires with the request still unserviced.

Top module: `refresh_arbiter`

## Requirements
- R1: During and right after a synchronous reset, `status_pin` and `refresh_start` are low, the request latch is empty, and the timer restarts its period.
- R2: The timer expires once every (period_code+1)*TICK_SCALE clock cycles and reloads itself on each expiry. With `auto_dis` low and nothing blocking, successive `refresh_start` pulses are exactly one period apart.
- R3: While `auto_dis` is high, timer expiries never lead to a `refresh_start`.
- R4: `strobe_n` low at a single clock edge sets the request latch. A `refresh_start` follows two edges later even though the strobe has returned high.
- R5: `refresh_start` is never raised in a cycle that follows an edge where `access_busy` was high or `precharge_ok` was low. A held request starts once both conditions clear.
- R6: `refresh_start` lasts one cycle. No new pulse appears until the current refresh has been ended with `refresh_end`.
- R7: With `ack_mode` low, `status_pin` is high from the cycle of the `refresh_start` pulse, which is one clock before the sequencer's RAS edge. It stays high until the edge at which `refresh_end` is sampled high, and is low after that edge.
- R8: If `strobe_n` is still low at the edge that ends a refresh, the latch stays set and another refresh follows. This gives a burst of any length.
- R9: The latch clears at the edge that ends the refresh, so one short strobe pulse yields exactly one refresh.
- R10: With `ack_mode` high, `status_pin` rises at the edge after the cycle in which the timer expires. It stays high until the edge that follows the `refresh_start` pulse that services it, whether that service is external or automatic.
- R11: With `ack_mode` high, if the timer expires again while the flag is still high and unserviced, `status_pin` is low for one cycle and then high again.
- R12: With `ack_mode` high, if a timer expiry falls in the same cycle as a `refresh_start`, `status_pin` stays high rather than dropping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| period_code | input | PERIOD_W | Programmed timer period code |
| auto_dis | input | 1 | High disables timer-driven refresh |
| strobe_n | input | 1 | External refresh request, active low |
| ack_mode | input | 1 | Selects request/acknowledge meaning for `status_pin` |
| access_busy | input | 1 | An access cycle is in progress |
| precharge_ok | input | 1 | RAS precharge time has been met |
| refresh_end | input | 1 | From the sequencer: last refresh RAS negates at this edge |
| refresh_start | output | 1 | One-cycle grant to the refresh sequencer |
| status_pin | output | 1 | Refresh in progress, or refresh due in request/acknowledge mode |

## Verification
In request/acknowledge mode, a timer expiry can land in the same cycle as the `refresh_start` that services the previous flag. One event wants to clear the flag and the other wants to set it. The bench provokes this by timing an external strobe so that its grant coincides exactly with the second timer expiry after reset. It then requires `status_pin` to stay high for the next two cycles, with no one-cycle dip. A second overlap is also exercised: a burst strobe held low across the edge that ends a refresh. That case is judged by the number of back-to-back grants and by the absence of any grant while a refresh is still open.

// File: rtl/refresh_arbiter.sv
module refresh_arbiter #(
  parameter int PERIOD_W   = 4,
  parameter int TICK_SCALE = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [PERIOD_W-1:0] period_code,
  input  logic                auto_dis,
  input  logic                strobe_n,
  input  logic                ack_mode,
  input  logic                access_busy,
  input  logic                precharge_ok,
  input  logic                refresh_end,
  output logic                refresh_start,
  output logic                status_pin
);

  localparam int CNT_W = PERIOD_W + $clog2(TICK_SCALE) + 1;

  logic [CNT_W-1:0] cnt, load;
  logic tick, req, announce, in_refresh, rfrq, redo, go;

  // period = (code+1)*scale cycles
  assign load = CNT_W'(period_code) * CNT_W'(TICK_SCALE) + CNT_W'(TICK_SCALE - 1);
  assign tick = (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst)       cnt <= load;
    else if (tick) cnt <= load;
    else           cnt <= cnt - 1'b1;
  end

  // shared request latch: strobe, timer, burst hold-over
  always_ff @(posedge clk) begin
    if (rst) req <= 1'b0;
    else     req <= !strobe_n || (tick && !auto_dis) || (req && !refresh_end);
  end

  assign go = req && !in_refresh && !announce && !access_busy && precharge_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      announce   <= 1'b0;
      in_refresh <= 1'b0;
    end else begin
      announce <= go;
      if (announce)         in_refresh <= 1'b1;
      else if (refresh_end) in_refresh <= 1'b0;
    end
  end

  // request flag for the handshake mode
  always_ff @(posedge clk) begin
    if (rst) begin
      rfrq <= 1'b0;
      redo <= 1'b0;
    end else begin
      redo <= tick && rfrq && !announce;
      if (tick)          rfrq <= !(rfrq && !announce);
      else if (announce) rfrq <= 1'b0;
      else if (redo)     rfrq <= 1'b1;
    end
  end

  assign refresh_start = announce;
  assign status_pin    = ack_mode ? rfrq : (announce || in_refresh);

  assert_start_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    refresh_start |=> !refresh_start);
  assert_no_overlap_R6: assert property (@(posedge clk) disable iff (rst)
    (in_refresh && !refresh_end) |=> !refresh_start);
  assert_start_gated_R5: assert property (@(posedge clk) disable iff (rst)
    refresh_start |-> $past(!access_busy && precharge_ok));
  assert_status_lead_R7: assert property (@(posedge clk) disable iff (rst)
    (!ack_mode && refresh_start) |-> status_pin);
  assert_flag_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (rfrq && !tick && !announce) |=> rfrq);
  assert_repulse_R11: assert property (@(posedge clk) disable iff (rst)
    ($fell(rfrq) && !$past(announce) && !announce) |=> rfrq);

endmodule

// File: tb/tb_refresh_arbiter.sv
module tb_refresh_arbiter;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [3:0] period_code = 4'd1;
  logic auto_dis = 1'b1, strobe_n = 1'b1, ack_mode = 1'b0;
  logic access_busy = 1'b0, precharge_ok = 1'b1, refresh_end = 1'b0;
  logic refresh_start, status_pin;

  int checks = 0, errors = 0;
  int cyc = 0, starts = 0, last_start = -1, prev_start = -1, ras_cnt = 0, overlap = 0;
  logic prev_pulse = 1'b0;

  always #2 clk = ~clk;

  refresh_arbiter #(.PERIOD_W(4), .TICK_SCALE(4)) dut (
    .clk(clk), .rst(rst), .period_code(period_code), .auto_dis(auto_dis),
    .strobe_n(strobe_n), .ack_mode(ack_mode), .access_busy(access_busy),
    .precharge_ok(precharge_ok), .refresh_end(refresh_end),
    .refresh_start(refresh_start), .status_pin(status_pin));

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // one clock edge plus a simple sequencer model with a 3-cycle RAS
  task automatic step();
    @(posedge clk); #1;
    cyc++;
    if (refresh_end) refresh_end = 1'b0;
    if (refresh_start) begin
      if (prev_pulse || ras_cnt > 0) overlap++;
      starts++;
      prev_start = last_start;
      last_start = cyc;
      ras_cnt = 3;
    end else if (ras_cnt > 0) begin
      ras_cnt--;
      if (ras_cnt == 0) refresh_end = 1'b1;
    end
    prev_pulse = refresh_start;
  endtask

  task automatic steps(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic do_reset(input logic [3:0] code, input logic dis, input logic ack);
    period_code = code; auto_dis = dis; ack_mode = ack;
    strobe_n = 1'b1; access_busy = 1'b0; precharge_ok = 1'b1; refresh_end = 1'b0;
    rst = 1'b1;
    steps(2);
    rst = 1'b0;
    cyc = 0; starts = 0; last_start = -1; prev_start = -1; ras_cnt = 0;
    overlap = 0; prev_pulse = 1'b0;
  endtask

  task automatic t_reset();
    do_reset(4'd1, 1'b0, 1'b0);
    check("R1 status after reset", status_pin, 0);
    check("R1 start after reset", refresh_start, 0);
  endtask

  task automatic t_auto_period();
    do_reset(4'd1, 1'b0, 1'b0);
    steps(40);
    check("R2 auto refresh count", starts >= 4, 1);
    check("R2 start spacing", last_start - prev_start, 8);
    check("R6 no overlap auto", overlap, 0);
  endtask

  task automatic t_disabled();
    do_reset(4'd0, 1'b1, 1'b0);
    steps(40);
    check("R3 no timer refresh when disabled", starts, 0);
  endtask

  task automatic t_strobe_single();
    do_reset(4'd15, 1'b1, 1'b0);
    strobe_n = 1'b0;
    step();
    strobe_n = 1'b1;
    check("R4 no start one edge after strobe", refresh_start, 0);
    check("R7 status low before grant", status_pin, 0);
    step();
    check("R4 start two edges after strobe", refresh_start, 1);
    check("R7 status high with start", status_pin, 1);
    steps(3);
    check("R7 status held in refresh", status_pin, 1);
    step();
    check("R7 status low after end", status_pin, 0);
    steps(12);
    check("R9 single strobe gives one refresh", starts, 1);
  endtask

  task automatic t_blocking();
    do_reset(4'd15, 1'b1, 1'b0);
    access_busy = 1'b1;
    strobe_n = 1'b0;
    step();
    strobe_n = 1'b1;
    steps(8);
    check("R5 held off by access", starts, 0);
    precharge_ok = 1'b0;
    access_busy = 1'b0;
    steps(6);
    check("R5 held off by precharge", starts, 0);
    precharge_ok = 1'b1;
    step();
    check("R5 start once clear", refresh_start, 1);
    steps(8);
    check("R5 exactly one start", starts, 1);
  endtask

  task automatic t_burst();
    do_reset(4'd15, 1'b1, 1'b0);
    strobe_n = 1'b0;
    steps(20);
    strobe_n = 1'b1;
    steps(12);
    check("R8 burst refresh count", starts, 4);
    check("R6 no overlap in burst", overlap, 0);
  endtask

  task automatic t_ack_external();
    do_reset(4'd1, 1'b1, 1'b1);
    steps(7);
    check("R10 flag low before expiry", status_pin, 0);
    step();
    check("R10 flag up after expiry", status_pin, 1);
    steps(8);
    check("R11 flag dips on missed period", status_pin, 0);
    step();
    check("R11 flag back up", status_pin, 1);
    strobe_n = 1'b0;
    step();
    strobe_n = 1'b1;
    step();
    check("R10 flag held until service", status_pin, 1);
    step();
    check("R10 flag cleared by service", status_pin, 0);
  endtask

  task automatic t_ack_auto();
    do_reset(4'd1, 1'b0, 1'b1);
    steps(8);
    check("R10 auto flag up", status_pin, 1);
    step();
    check("R10 auto flag held during grant", status_pin, 1);
    step();
    check("R10 auto flag cleared", status_pin, 0);
  endtask

  task automatic t_ack_collide();
    do_reset(4'd1, 1'b1, 1'b1);
    steps(13);
    strobe_n = 1'b0;
    step();
    strobe_n = 1'b1;
    step();
    check("R12 grant aligned with expiry", refresh_start, 1);
    step();
    check("R12 flag kept on collision", status_pin, 1);
    step();
    check("R12 no dip after collision", status_pin, 1);
  endtask

  initial begin
    t_reset();
    t_auto_period();
    t_disabled();
    t_strobe_single();
    t_blocking();
    t_burst();
    t_ack_external();
    t_ack_auto();
    t_ack_collide();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule